// File: doc/BRIEF.md
# Control Code Min-Max Averager

This block sits beside a tracking oscillator loop and turns its dithering control code into a steady one. Over a window of a fixed number of reference clock cycles, it records the highest and the lowest code that arrive with a valid strobe. When the window closes, it publishes the midpoint of those two extremes. The published code drives a second oscillator, which then runs free of the tracking loop's small up-and-down motion.

While `enable` stays high, windows follow one another with no gap. The window length is counted in clock cycles, not in valid samples. Every window starts empty, and its first valid sample sets both extremes. The output register and its valid flag change only at the close of a window. Between closes they keep their values. Dropping `enable` throws away the partial window and restarts the cycle count, but the last published code stays in place.

Top module: `minmax_avg`

## Requirements
- R1: While `rst` is high, at each clock edge `avg_vld` goes to 0 and `avg_code` goes to 0.
- R2: A window is exactly WIN_LEN (default 256) consecutive clock cycles with `enable` high. A valid sample taken on the last cycle of the window still counts. The output is updated at the clock edge that ends that last cycle.
- R3: The largest valid code seen during the window is the upper extreme.
- R4: The smallest valid code seen during the window is the lower extreme.
- R5: The published code is floor((upper + lower) / 2), formed with one extra bit so that it is correct at full scale. For example, 0x1FFFF and 0x1FFFE give 0x1FFFE.
- R6: The first valid sample of each window sets both extremes. Codes from earlier windows have no effect.
- R7: A cycle with `code_vld` low contributes nothing, whatever value `code_in` carries.
- R8: Between window ends, `avg_code` and `avg_vld` hold their values.
- R9: While `enable` stays high, windows repeat back to back. Once `avg_vld` is set, it stays set until reset.
- R10: When `enable` goes low, the partial window is discarded and the outputs hold. When `enable` rises again, a full new window of WIN_LEN cycles begins.
- R11: If a window closes with no valid sample, the outputs are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs windows while high |
| code_in | input | 17 | Live tracking control code |
| code_vld | input | 1 | Qualifies `code_in` in this cycle |
| avg_code | output | 17 | Midpoint of the last completed window |
| avg_vld | output | 1 | Set after the first window that had a valid sample |

## Verification
The assertions assume that `enable` and `code_vld` are clean synchronous levels. They also assume that any window whose result is checked holds `enable` high for its whole length, so the cycle count advances by one on every enabled cycle. The stimulus changes inputs only on the falling clock edge. It keeps `enable` high through every scored window and lowers it only in the deliberate abort case. The expected midpoint for each window is taken from the samples the bench actually marked valid.

// File: rtl/mma_pkg.sv
package mma_pkg;

    localparam int unsigned CODE_W = 17;
    localparam int unsigned SUM_W  = CODE_W + 1;

    typedef logic [CODE_W-1:0] code_t;

    // running extremes of the current window
    typedef struct packed {
        logic  seen;
        code_t hi;
        code_t lo;
    } span_t;

    localparam span_t SPAN_EMPTY = '{seen: 1'b0, hi: '0, lo: '0};

    function automatic span_t span_merge(span_t s, code_t c);
        span_t r;
        if (!s.seen) begin
            r.seen = 1'b1;
            r.hi   = c;
            r.lo   = c;
        end else begin
            r.seen = 1'b1;
            r.hi   = (c > s.hi) ? c : s.hi;
            r.lo   = (c < s.lo) ? c : s.lo;
        end
        return r;
    endfunction

    function automatic code_t span_mid(span_t s);
        logic [SUM_W-1:0] total;
        total = {1'b0, s.hi} + {1'b0, s.lo};
        return total[SUM_W-1:1];
    endfunction

endpackage

// File: rtl/mma_window_ctr.sv
module mma_window_ctr #(
    parameter int unsigned WIN_LEN = 256,
    parameter int unsigned CNT_W   = $clog2(WIN_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    output logic [CNT_W-1:0] cnt,
    output logic             win_first,
    output logic             win_last
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_LEN - 1);

    assign win_first = enable && (cnt == '0);
    assign win_last  = enable && (cnt == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!enable || win_last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mma_span_track.sv
module mma_span_track
    import mma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  win_first,
    input  code_t code_in,
    input  logic  code_vld,
    output span_t cur,
    output span_t nxt
);

    span_t base;

    always_comb begin
        base = win_first ? SPAN_EMPTY : cur;
        nxt  = code_vld ? span_merge(base, code_in) : base;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cur <= SPAN_EMPTY;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/mma_out_reg.sv
module mma_out_reg
    import mma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  win_last,
    input  span_t nxt,
    output code_t avg_code,
    output logic  avg_vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            avg_code <= '0;
            avg_vld  <= 1'b0;
        end else if (win_last && nxt.seen) begin
            avg_code <= span_mid(nxt);
            avg_vld  <= 1'b1;
        end
    end

endmodule

// File: rtl/minmax_avg.sv
module minmax_avg
    import mma_pkg::*;
#(
    parameter int unsigned WIN_LEN = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_vld,
    output logic [CODE_W-1:0] avg_code,
    output logic              avg_vld
);

    localparam int unsigned CNT_W = $clog2(WIN_LEN);

    logic [CNT_W-1:0] cnt;
    logic             win_first;
    logic             win_last;
    span_t            cur;
    span_t            nxt;

    mma_window_ctr #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .cnt      (cnt),
        .win_first(win_first),
        .win_last (win_last)
    );

    mma_span_track u_trk (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .win_first(win_first),
        .code_in  (code_in),
        .code_vld (code_vld),
        .cur      (cur),
        .nxt      (nxt)
    );

    mma_out_reg u_out (
        .clk     (clk),
        .rst     (rst),
        .win_last(win_last),
        .nxt     (nxt),
        .avg_code(avg_code),
        .avg_vld (avg_vld)
    );

endmodule

// File: rtl/minmax_avg_chk.sv
module minmax_avg_chk
    import mma_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             win_last,
    input logic [CNT_W-1:0] cnt,
    input span_t            cur,
    input code_t            avg_code,
    input logic             avg_vld
);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!avg_vld && avg_code == '0));

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !win_last |=> ($stable(avg_code) && $stable(avg_vld)));

    // R3 R4
    span_order_chk: assert property (@(posedge clk) disable iff (rst)
        cur.seen |-> (cur.hi >= cur.lo));

    // R10
    abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt == '0 && !cur.seen));

    // R2
    cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !win_last) |=> (cnt == $past(cnt) + 1'b1));

    // R9
    vld_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        avg_vld |=> avg_vld);

endmodule

bind minmax_avg minmax_avg_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .win_last(win_last),
    .cnt     (cnt),
    .cur     (cur),
    .avg_code(avg_code),
    .avg_vld (avg_vld)
);

// File: tb/minmax_avg_tb.sv
module minmax_avg_tb;

    localparam int WIN = 256;
    localparam int CW  = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic [CW-1:0] code_in = '0;
    logic          code_vld = 1'b0;
    logic [CW-1:0] avg_code;
    logic          avg_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [CW-1:0] exp_code = '0;
    logic          exp_vld  = 1'b0;

    logic [CW-1:0] q_code[$];
    logic          q_vld[$];
    string         q_tag[$];

    always #2 clk = ~clk;

    minmax_avg #(.WIN_LEN(WIN)) u_dut (
        .clk(clk), .rst(rst), .enable(enable),
        .code_in(code_in), .code_vld(code_vld),
        .avg_code(avg_code), .avg_vld(avg_vld)
    );

    task automatic check(string tag, logic [CW-1:0] c, logic v);
        checks++;
        if (avg_code !== c || avg_vld !== v) begin
            fails++;
            $display("FAIL %s: got code=%h vld=%b, expected code=%h vld=%b",
                     tag, avg_code, avg_vld, c, v);
        end
    endtask

    task automatic pattern(int kind, int i, output logic [CW-1:0] c, output logic v);
        case (kind)
            0: begin c = CW'(50000 + (i * 37) % 23); v = 1'b1; end
            1: begin v = (i % 3) != 0; c = v ? CW'(20000 + i % 11) : 17'h1FFFF; end
            2: begin c = (i % 2) ? 17'h1FFFF : 17'h1FFFE; v = 1'b1; end
            3: begin c = CW'(i * 91); v = 1'b0; end
            4: begin c = CW'(5 + i % 4); v = 1'b1; end
            5: begin c = (i == WIN - 1) ? CW'(777) : 17'h1FFFF; v = (i == WIN - 1); end
            6: begin c = (i % 2) ? 17'h1FFFF : '0; v = 1'b1; end
            default: begin c = CW'(3000 + i % 5); v = 1'b1; end
        endcase
    endtask

    // driver: one window (or a partial one when n < WIN)
    task automatic run(int kind, int n, string tag);
        int lo = 0;
        int hi = 0;
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic [CW-1:0] c;
            logic v;
            if (i == WIN / 2) check("R8 mid-window hold", exp_code, exp_vld);
            pattern(kind, i, c, v);
            code_in  = c;
            code_vld = v;
            if (v) begin
                if (!seen || int'(c) > hi) hi = int'(c);
                if (!seen || int'(c) < lo) lo = int'(c);
                seen = 1'b1;
            end
            @(negedge clk);
        end
        if (n == WIN) begin
            if (seen) begin
                exp_code = CW'((hi + lo) >> 1);
                exp_vld  = 1'b1;
            end
            q_code.push_back(exp_code);
            q_vld.push_back(exp_vld);
            q_tag.push_back(tag);
        end
    endtask

    // monitor: compares each window result after the closing edge
    initial begin
        forever begin
            wait (q_code.size() != 0);
            #1;
            check(q_tag.pop_front(), q_code.pop_front(), q_vld.pop_front());
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", '0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset, idle", '0, 1'b0);

        enable = 1'b1;
        run(0, WIN, "R3 R4 dithered window");
        run(1, WIN, "R7 gaps carry ignored full-scale codes");
        run(2, WIN, "R5 full-scale midpoint");
        run(4, WIN, "R6 fresh extremes after large window");
        run(3, WIN, "R11 window with no valid sample");
        run(5, WIN, "R2 sample on last cycle counts");
        run(7, WIN, "R9 back-to-back window");

        // R10: abort a poisoned window part way
        run(6, 100, "R10 partial");
        enable   = 1'b0;
        code_vld = 1'b0;
        repeat (5) @(negedge clk);
        check("R10 outputs hold after abort", exp_code, exp_vld);
        enable = 1'b1;
        run(4, WIN, "R10 full window after re-enable");
        enable = 1'b0;
        @(negedge clk);
        #2;
        check("R8 hold while disabled", exp_code, exp_vld);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule